// File: doc/BRIEF.md
# Pause-Width Frame Transmitter

This block sends one reader-to-card frame on a single active-high carrier-enable line, and counts time in clock cycles. Each symbol starts with a fixed low pause and then returns high. A one and a zero are told apart only by how long the symbol lasts, measured from the start of its pause. Each data bit is scrambled with a keystream bit from an external generator before it goes on air. After each bit the block pulses an advance output so that the generator steps to its next position.

The block keeps a free-running timestamp and remembers when the previous frame ended. Every interval (the guard before a frame, each pause, each symbol remainder) is added to a target time instead of being counted from the moment an event is seen. Frames that follow each other therefore keep their spacing exactly, with no drift. When a start strobe comes after the guard has already run out, the block rebases on the strobe and keeps the same additive timing from there. A frame ends with one more pause, and done pulses when that pause is over.

Top module: `pwtx_frame_tx`

## Requirements
- R1: Out of reset and whenever no frame is in progress, `carrier_en` is 1, while `done` and `ks_adv` are 0.
- R2: Every pause drives `carrier_en` low for exactly PAUSE_T = 30 clock cycles, after which it returns to 1.
- R3: A symbol whose on-air value is 1 spans 150 cycles from its falling edge to the next falling edge. A symbol whose on-air value is 0 spans 90 cycles.
- R4: Frame bits are sent from bit 0 of `frame_data` upward. The on-air value of each bit is the data bit XOR the `ks_bit` level present at the clock edge that starts that bit's pause.
- R5: `ks_adv` is a one-cycle pulse that is high in the first low cycle of each data-bit pause. A frame produces exactly as many pulses as it has bits, and the closing pause produces none.
- R6: When a start strobe comes early enough, the first pause begins 330 cycles after the cycle in which `done` was high for the previous frame. After reset, the reference is the first cycle following reset release.
- R7: When a start strobe comes later than that point, the first pause begins on the clock edge right after the edge that accepted the strobe.
- R8: One extra 30-cycle pause follows the last symbol. `done` is high for one cycle only, in the cycle where `carrier_en` rises at the end of that pause.
- R9: A length of 0 produces the guard wait and the closing pause only.
- R10: A `frame_len` above MAX_BITS (32) is treated as 32.
- R11: A start strobe that arrives while a frame is in progress is ignored. The frame in progress keeps its timing and data, and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Strobe that requests a frame; ignored while busy |
| frame_data | input | MAX_BITS | Frame word, bit 0 is sent first |
| frame_len | input | LEN_W | Number of bits to send (0 to 32, larger values clamp) |
| ks_bit | input | 1 | Current keystream bit from the external generator |
| ks_adv | output | 1 | One-cycle request to step the keystream |
| carrier_en | output | 1 | Carrier enable; low during pauses |
| done | output | 1 | One-cycle pulse when the closing pause ends |

## Verification
The bench drives plain frames with the keystream held at zero, so that bit order and the 150/90 symbol lengths show up directly. It then turns on a position-dependent keystream, which shows whether the XOR is applied with the bit that is current at each pause. A frame started right on `done` exercises the guard measured from the stored end time. A frame started long after the previous one exercises the rebasing path. Frames of length 0, 1, 32 and an oversized length cover the edges of the bit counter. A second strobe sent in the middle of a frame must leave the expected event stream unchanged.

// File: rtl/pwtx_pkg.sv
`timescale 1ns/1ps
package pwtx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GUARD,
    ST_PAUSE,
    ST_MARK,
    ST_CLOSE
  } pwtx_state_e;

  // Ticks the carrier stays high after a pause, by on-air bit value
  function automatic int unsigned mark_ticks(input logic one,
                                             input int unsigned t_one,
                                             input int unsigned t_zero,
                                             input int unsigned t_pause);
    return (one ? t_one : t_zero) - t_pause;
  endfunction

  // Requested length limited to the frame register size
  function automatic int unsigned clamp_len(input int unsigned len,
                                            input int unsigned max_len);
    return (len > max_len) ? max_len : len;
  endfunction

endpackage

// File: rtl/pwtx_timebase.sv
`timescale 1ns/1ps
module pwtx_timebase #(
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TS_W-1:0] target,
  output logic [TS_W-1:0] now,
  output logic            reached
);

  logic [TS_W-1:0] now_q;
  logic [TS_W-1:0] diff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) now_q <= '0;
    else        now_q <= now_q + TS_W'(1);
  end

  // Modular comparison: target is reached once now is not behind it
  assign diff    = now_q - target;
  assign reached = ~diff[TS_W-1];
  assign now     = now_q;

endmodule

// File: rtl/pwtx_bitsrc.sv
`timescale 1ns/1ps
module pwtx_bitsrc
  import pwtx_pkg::*;
#(
  parameter int MAX_BITS = 32,
  parameter int LEN_W    = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [MAX_BITS-1:0] data_in,
  input  logic [LEN_W-1:0]    len_in,
  input  logic                step,
  input  logic                ks_bit,
  output logic                air_bit,
  output logic                empty
);

  logic [MAX_BITS-1:0] data_q;
  logic [LEN_W-1:0]    rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      rem_q  <= '0;
    end else if (load) begin
      data_q <= data_in;
      rem_q  <= LEN_W'(clamp_len(int'(len_in), MAX_BITS));
    end else if (step) begin
      data_q <= data_q >> 1;
      rem_q  <= rem_q - LEN_W'(1);
    end
  end

  assign air_bit = data_q[0] ^ ks_bit;
  assign empty   = (rem_q == '0);

endmodule

// File: rtl/pwtx_frame_tx.sv
`timescale 1ns/1ps
module pwtx_frame_tx
  import pwtx_pkg::*;
#(
  parameter int MAX_BITS = 32,
  parameter int LEN_W    = $clog2(MAX_BITS + 1),
  parameter int TS_W     = 32,
  parameter int PAUSE_T  = 30,
  parameter int ONE_T    = 150,
  parameter int ZERO_T   = 90,
  parameter int GUARD_T  = 330
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [MAX_BITS-1:0] frame_data,
  input  logic [LEN_W-1:0]    frame_len,
  input  logic                ks_bit,
  output logic                ks_adv,
  output logic                carrier_en,
  output logic                done
);

  localparam logic [TS_W-1:0] PAUSE_TS = TS_W'(PAUSE_T);
  localparam logic [TS_W-1:0] GUARD_TS = TS_W'(GUARD_T);

  pwtx_state_e     state_q;
  logic [TS_W-1:0] tgt_q;
  logic [TS_W-1:0] end_q;
  logic            sym_q;
  logic            carrier_q;
  logic            done_q;
  logic            adv_q;

  logic [TS_W-1:0] now;
  logic            reached;
  logic            air_bit;
  logic            empty;

  // Named events, also observed by the checker
  logic            busy;
  logic            load;
  logic            slot_hit;
  logic            step;
  logic [TS_W-1:0] guard_end;
  logic [TS_W-1:0] next_slot;
  logic [TS_W-1:0] gdiff;
  logic [TS_W-1:0] frame_base;

  assign busy      = (state_q != ST_IDLE);
  assign load      = start && !busy;
  assign slot_hit  = reached && ((state_q == ST_GUARD) || (state_q == ST_MARK));
  assign step      = slot_hit && !empty;

  // Later of (previous end + guard) and (next cycle)
  assign guard_end  = end_q + GUARD_TS;
  assign next_slot  = now + TS_W'(1);
  assign gdiff      = guard_end - next_slot;
  assign frame_base = gdiff[TS_W-1] ? next_slot : guard_end;

  pwtx_timebase #(.TS_W(TS_W)) u_tb (
    .clk     (clk),
    .rst_n   (rst_n),
    .target  (tgt_q),
    .now     (now),
    .reached (reached)
  );

  pwtx_bitsrc #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) u_bits (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .data_in (frame_data),
    .len_in  (frame_len),
    .step    (step),
    .ks_bit  (ks_bit),
    .air_bit (air_bit),
    .empty   (empty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      tgt_q     <= '0;
      end_q     <= '0;
      sym_q     <= 1'b0;
      carrier_q <= 1'b1;
      done_q    <= 1'b0;
      adv_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      adv_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (load) begin
            tgt_q   <= frame_base;
            state_q <= ST_GUARD;
          end
        end
        ST_GUARD, ST_MARK: begin
          if (slot_hit) begin
            carrier_q <= 1'b0;
            tgt_q     <= tgt_q + PAUSE_TS;
            if (empty) begin
              state_q <= ST_CLOSE;
            end else begin
              sym_q   <= air_bit;
              adv_q   <= 1'b1;
              state_q <= ST_PAUSE;
            end
          end
        end
        ST_PAUSE: begin
          if (reached) begin
            carrier_q <= 1'b1;
            tgt_q     <= tgt_q + TS_W'(mark_ticks(sym_q, ONE_T, ZERO_T, PAUSE_T));
            state_q   <= ST_MARK;
          end
        end
        ST_CLOSE: begin
          if (reached) begin
            carrier_q <= 1'b1;
            done_q    <= 1'b1;
            end_q     <= tgt_q;
            state_q   <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign carrier_en = carrier_q;
  assign done       = done_q;
  assign ks_adv     = adv_q;

endmodule

// File: rtl/pwtx_frame_tx_chk.sv
`timescale 1ns/1ps
module pwtx_frame_tx_chk #(
  parameter int PAUSE_T = 30,
  parameter int ONE_T   = 150,
  parameter int ZERO_T  = 90
) (
  input logic clk,
  input logic rst_n,
  input logic carrier_en,
  input logic done,
  input logic ks_adv,
  input logic busy
);

  logic [31:0] low_run;
  logic [31:0] since_fall;
  logic        c_d;
  logic        in_frame;
  logic        fell_now;

  assign fell_now = c_d && !carrier_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run    <= '0;
      since_fall <= '0;
      c_d        <= 1'b1;
      in_frame   <= 1'b0;
    end else begin
      c_d        <= carrier_en;
      low_run    <= carrier_en ? '0 : low_run + 32'd1;
      since_fall <= fell_now ? 32'd1 : since_fall + 32'd1;
      if (done)          in_frame <= 1'b0;
      else if (fell_now) in_frame <= 1'b1;
    end
  end

  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> carrier_en);

  a_r2_pause_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(carrier_en) |-> (low_run == 32'(PAUSE_T)));

  a_r3_symbol_span: assert property (@(posedge clk) disable iff (!rst_n)
    (fell_now && in_frame) |-> (since_fall == 32'(ONE_T) || since_fall == 32'(ZERO_T)));

  a_r5_adv_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    ks_adv |-> $fell(carrier_en));

  a_r8_done_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $rose(carrier_en));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind pwtx_frame_tx pwtx_frame_tx_chk #(
  .PAUSE_T (PAUSE_T),
  .ONE_T   (ONE_T),
  .ZERO_T  (ZERO_T)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .carrier_en (carrier_en),
  .done       (done),
  .ks_adv     (ks_adv),
  .busy       (busy)
);

// File: tb/sim_pwtx_frame_tx.sv
`timescale 1ns/1ps
module sim_pwtx_frame_tx;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [31:0] frame_data;
  logic [5:0]  frame_len;
  logic        ks_bit;
  logic        ks_adv;
  logic        carrier_en;
  logic        done;

  int checks = 0;
  int errors = 0;
  int cyc;
  int ks_idx;
  logic ks_on = 1'b0;
  bit finished = 1'b0;

  // Scoreboard queues
  int    q_fall[$];
  int    q_rise[$];
  string q_tag[$];
  int    q_done[$];

  int last_done = 1;  // reference after reset (R6)
  int ks_base   = 0;
  int adv_exp   = 0;
  int adv_seen  = 0;
  int fall_seen = 0;
  logic c_prev  = 1'b1;

  always #4 clk = ~clk;  // 125 MHz

  pwtx_frame_tx u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .frame_data (frame_data),
    .frame_len  (frame_len),
    .ks_bit     (ks_bit),
    .ks_adv     (ks_adv),
    .carrier_en (carrier_en),
    .done       (done)
  );

  function automatic logic ks_fn(input int i);
    return i[0] ^ i[2] ^ i[3];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  // Bench-owned keystream generator
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ks_idx <= 0;
    else if (ks_adv) ks_idx <= ks_idx + 1;
  end
  assign ks_bit = ks_on & ks_fn(ks_idx);

  // Monitor: compares observed pauses and done against expectations
  always @(negedge clk) begin
    int ef, er, ed;
    string tg;
    if (rst_n === 1'b1) begin
      if (c_prev && !carrier_en) fall_seen = cyc;
      if (!c_prev && carrier_en) begin
        checks++;
        if (q_rise.size() == 0) begin
          errors++;
          $display("FAIL R11 unexpected pause fall=%0d rise=%0d, expected none", fall_seen, cyc);
        end else begin
          ef = q_fall.pop_front();
          er = q_rise.pop_front();
          tg = q_tag.pop_front();
          if (fall_seen != ef || cyc != er) begin
            errors++;
            $display("FAIL %s pause fall/rise=%0d/%0d expected %0d/%0d", tg, fall_seen, cyc, ef, er);
          end
        end
      end
      if (done) begin
        checks++;
        if (q_done.size() == 0) begin
          errors++;
          $display("FAIL R8 done at %0d expected none", cyc);
        end else begin
          ed = q_done.pop_front();
          if (cyc != ed) begin
            errors++;
            $display("FAIL R8 done cycle %0d expected %0d", cyc, ed);
          end
        end
      end
      if (ks_adv) adv_seen++;
    end
    c_prev = carrier_en;
  end

  // Driver: pushes expected pauses, then starts the frame
  task automatic send(input logic [31:0] d, input int len, input bit poke, input string tag);
    int n0, t, eff;
    logic b;
    @(negedge clk);
    n0  = cyc;
    eff = (len > 32) ? 32 : len;                       // R10
    t   = (last_done + 330 > n0 + 2) ? last_done + 330 : n0 + 2;  // R6, R7
    for (int i = 0; i < eff; i++) begin
      b = d[i] ^ (ks_on & ks_fn(ks_base + i));         // R4
      q_fall.push_back(t);
      q_rise.push_back(t + 30);                        // R2
      q_tag.push_back(tag);
      t += b ? 150 : 90;                               // R3
    end
    q_fall.push_back(t);
    q_rise.push_back(t + 30);
    q_tag.push_back("R8 closing pause");
    q_done.push_back(t + 30);
    last_done = t + 30;
    ks_base  += eff;
    adv_exp  += eff;                                   // R5
    frame_data = d;
    frame_len  = 6'(len);
    start      = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    if (poke) begin                                    // R11
      repeat (400) @(negedge clk);
      frame_data = ~d;
      frame_len  = 6'd3;
      start      = 1'b1;
      @(posedge clk);
      #1 start = 1'b0;
    end
    while (cyc < last_done + 2) @(negedge clk);
  endtask

  task automatic check_eq(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  initial begin
    rst_n      = 1'b0;
    start      = 1'b0;
    frame_data = '0;
    frame_len  = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle state after reset
    check_eq(int'(carrier_en), 1, "R1 carrier idle");
    check_eq(int'(done), 0, "R1 done idle");
    check_eq(int'(ks_adv), 0, "R1 ks_adv idle");

    send(32'h0000_0055, 7, 1'b0, "R3,R4,R6 plain frame after reset");
    ks_on = 1'b1;
    send(32'h0000_02B5, 11, 1'b0, "R4,R6 keyed back-to-back frame");
    repeat (1000) @(negedge clk);
    send(32'hA5C3_0F96, 32, 1'b0, "R7,R4 late start full frame");
    send(32'h0000_0000, 0, 1'b0, "R9 empty frame");
    send(32'h0000_0001, 1, 1'b0, "R3 single bit");
    send(32'hFFFF_0001, 45, 1'b0, "R10 clamped length");
    ks_on = 1'b0;
    send(32'h000F_3C5A, 20, 1'b1, "R11 strobe while busy");

    repeat (600) @(negedge clk);
    check_eq(q_rise.size() + q_done.size(), 0, "R11 leftover expectations");
    check_eq(adv_seen, adv_exp, "R5 keystream advance count");
    check_eq(int'(carrier_en), 1, "R1 carrier idle at end");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired, actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule